// File: doc/BRIEF.md
# Firmware Memory Cycle Snooper for a Low Pin Count Bus

This block listens passively to a Low Pin Count bus. It samples the active-low frame strobe and the four multiplexed data lines on every clock edge, and it recognises firmware memory reads and writes. For each such cycle it follows the select nibble, the 28-bit address, the size code, the turnaround, the SYNC handshake and the data nibbles. When a cycle completes, it presents one record that holds the direction, the select value, the address, the size code, the assembled data and the number of bytes kept. It never drives the bus. Ordinary I/O and memory cycles, DMA and bus mastering are ignored. Transfers larger than the configured storage are still followed to the end, but only the first `MAX_BYTES` bytes are stored, and an overflow error is reported.

The controller has nine states. From IDLE, a firmware start enters SELECT. SELECT always moves to ADDRESS. ADDRESS moves to SIZE after seven nibbles. From SIZE, an invalid code returns to IDLE. A valid code moves a write to WDATA and a read to TURN. WDATA moves to TURN after the last nibble. TURN moves to SYNC after two clocks. In SYNC, a wait code keeps the controller in SYNC. A ready code completes a write (back to IDLE) or moves a read to RDATA. A frame strobe seen in SYNC moves to ABORT. RDATA completes the read and returns to IDLE. ABORT returns to IDLE after its remaining three clocks. In every state except SYNC and ABORT, a frame strobe together with a firmware start re-enters SELECT. A frame strobe with any other nibble drops to IDLE.

Top module: `fwcyc_snoop`

## Requirements
- R1: A clock with `lpc_frame_n` low and `lpc_lad` = 4'b1101 starts a firmware read, and 4'b1110 starts a firmware write. A frame strobe with any other nibble produces no record and no error.
- R2: After the start come one select nibble, then seven address nibbles (most significant first, forming a 28-bit address), then one size nibble. These appear on `rec_sel`, `rec_addr` and `rec_size`.
- R3: The size codes 4'b0000, 4'b0001, 4'b0010, 4'b0100 and 4'b0111 mean 1, 2, 4, 16 and 128 bytes. The bus carries two data nibbles per byte.
- R4: Any other size code pulses `err_valid` with `err_code` = 1 one clock after the size nibble. No record is produced, and the monitor returns to idle.
- R5: On a write, the data nibbles follow the size nibble directly, then two turnaround clocks, then SYNC. The record appears one clock after the ready SYNC nibble, with `rec_write` = 1.
- R6: On a read, two turnaround clocks and SYNC follow the size nibble, and the data comes after the ready SYNC. The record appears one clock after the last data nibble, with `rec_write` = 0.
- R7: Each byte arrives low nibble first. Bytes fill `rec_data` in arrival order, with the first byte in bits [7:0].
- R8: During SYNC, the nibbles 4'b0101 and 4'b0110 (wait) and all non-ready values keep the monitor waiting. Only 4'b0000 or 4'b1001 is ready.
- R9: A frame strobe during SYNC pulses `err_valid` with `err_code` = 2 one clock later. The monitor ignores the bus for the following three clocks and then returns to idle.
- R10: Outside SYNC and abort, a frame strobe with a firmware start restarts decoding and discards the partial cycle. A frame strobe with any other nibble silently drops the partial cycle.
- R11: Bytes beyond `MAX_BYTES` are consumed but not stored. `rec_bytes` reports the number of bytes stored, and the record of such a transfer carries `err_valid` with `err_code` = 3 in the same clock.
- R12: `rec_valid` and `err_valid` are single-clock pulses, and both are low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lpc_frame_n | input | 1 | Sampled frame strobe, active low |
| lpc_lad | input | 4 | Sampled multiplexed address/data nibble |
| rec_valid | output | 1 | One-clock pulse when a record is presented |
| rec_write | output | 1 | 1 for a firmware write, 0 for a read |
| rec_sel | output | 4 | Select nibble of the cycle |
| rec_addr | output | 28 | Assembled address |
| rec_size | output | 4 | Size code as seen on the bus |
| rec_data | output | 8*MAX_BYTES | Stored data, first byte in the low lane |
| rec_bytes | output | $clog2(MAX_BYTES+1) | Number of bytes stored |
| err_valid | output | 1 | One-clock error pulse |
| err_code | output | 2 | 1 invalid size, 2 abort, 3 overflow |

## Verification
The bench builds the snooper with `MAX_BYTES` = 4, so the data word is 32 bits. With this setting, 16-byte and 128-byte transfers exceed the storage. The truncation path, the stored byte count and the overflow code all come within reach, while the full 256-nibble transfer is still followed to its end. One-, two- and four-byte transfers fit exactly, and they check lane placement up to the storage limit.

// File: rtl/fwcyc_pkg.sv
package fwcyc_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_SEL,
        S_ADDR,
        S_SIZE,
        S_WDATA,
        S_TURN,
        S_SYNC,
        S_RDATA,
        S_ABORT
    } fw_state_e;

    typedef enum logic [1:0] {
        E_NONE  = 2'd0,
        E_SIZE  = 2'd1,
        E_ABORT = 2'd2,
        E_OVF   = 2'd3
    } fw_err_e;

    localparam logic [3:0] START_RD   = 4'b1101;
    localparam logic [3:0] START_WR   = 4'b1110;
    localparam logic [3:0] SYNC_RDY   = 4'b0000;
    localparam logic [3:0] SYNC_RDY_M = 4'b1001;
    localparam logic [3:0] SYNC_SWAIT = 4'b0101;
    localparam logic [3:0] SYNC_LWAIT = 4'b0110;
    localparam int         ADDR_NIBS  = 7;

    // Byte count for a size code; zero marks an unsupported code.
    function automatic logic [7:0] size_bytes(input logic [3:0] code);
        logic [7:0] n;
        case (code)
            4'b0000: n = 8'd1;
            4'b0001: n = 8'd2;
            4'b0010: n = 8'd4;
            4'b0100: n = 8'd16;
            4'b0111: n = 8'd128;
            default: n = 8'd0;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/fwcyc_ctrl.sv
module fwcyc_ctrl
    import fwcyc_pkg::*;
#(
    parameter int MAX_BYTES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_n,
    input  logic [3:0] lad,
    output logic [8:0] cnt,
    output logic       cap_sel,
    output logic       cap_addr,
    output logic       cap_size,
    output logic       cap_data,
    output logic       clr,
    output logic       wr,
    output logic       rec_valid,
    output logic       err_valid,
    output logic [1:0] err_code
);

    localparam int         NSLOT_I  = 2 * MAX_BYTES;
    localparam logic [8:0] NSLOT    = 9'(NSLOT_I);
    localparam logic [8:0] ADDR_END = 9'(ADDR_NIBS - 1);

    fw_state_e  st, st_nx;
    logic [8:0] cnt_nx;
    logic [8:0] tot, tot_nx;
    logic       wr_nx;
    logic       done;
    logic       err;
    fw_err_e    ecode;
    logic       is_start;
    logic       in_guarded;
    logic [7:0] sz_b;

    assign is_start   = !frame_n && (lad == START_RD || lad == START_WR);
    assign in_guarded = (st == S_SYNC) || (st == S_ABORT);
    assign sz_b       = size_bytes(lad);

    always_comb begin
        st_nx    = st;
        cnt_nx   = cnt;
        tot_nx   = tot;
        wr_nx    = wr;
        cap_sel  = 1'b0;
        cap_addr = 1'b0;
        cap_size = 1'b0;
        cap_data = 1'b0;
        clr      = 1'b0;
        done     = 1'b0;
        err      = 1'b0;
        ecode    = E_NONE;
        if (!in_guarded && is_start) begin
            st_nx  = S_SEL;
            wr_nx  = (lad == START_WR);
            cnt_nx = '0;
            clr    = 1'b1;
        end else if (!in_guarded && st != S_IDLE && !frame_n) begin
            st_nx  = S_IDLE;
            cnt_nx = '0;
        end else begin
            unique case (st)
                S_IDLE: begin
                    st_nx = S_IDLE;
                end
                S_SEL: begin
                    cap_sel = 1'b1;
                    cnt_nx  = '0;
                    st_nx   = S_ADDR;
                end
                S_ADDR: begin
                    cap_addr = 1'b1;
                    if (cnt == ADDR_END) begin
                        cnt_nx = '0;
                        st_nx  = S_SIZE;
                    end else begin
                        cnt_nx = cnt + 9'd1;
                    end
                end
                S_SIZE: begin
                    cap_size = 1'b1;
                    cnt_nx   = '0;
                    if (sz_b == 8'd0) begin
                        st_nx = S_IDLE;
                        err   = 1'b1;
                        ecode = E_SIZE;
                    end else begin
                        tot_nx = {sz_b, 1'b0};
                        st_nx  = wr ? S_WDATA : S_TURN;
                    end
                end
                S_WDATA, S_RDATA: begin
                    cap_data = (cnt < NSLOT);
                    if (cnt == tot - 9'd1) begin
                        cnt_nx = '0;
                        if (st == S_WDATA) begin
                            st_nx = S_TURN;
                        end else begin
                            st_nx = S_IDLE;
                            done  = 1'b1;
                        end
                    end else begin
                        cnt_nx = cnt + 9'd1;
                    end
                end
                S_TURN: begin
                    if (cnt == 9'd1) begin
                        cnt_nx = '0;
                        st_nx  = S_SYNC;
                    end else begin
                        cnt_nx = cnt + 9'd1;
                    end
                end
                S_SYNC: begin
                    if (!frame_n) begin
                        st_nx  = S_ABORT;
                        cnt_nx = '0;
                        err    = 1'b1;
                        ecode  = E_ABORT;
                    end else if (lad == SYNC_RDY || lad == SYNC_RDY_M) begin
                        cnt_nx = '0;
                        if (wr) begin
                            st_nx = S_IDLE;
                            done  = 1'b1;
                        end else begin
                            st_nx = S_RDATA;
                        end
                    end
                end
                S_ABORT: begin
                    if (cnt == 9'd2) begin
                        cnt_nx = '0;
                        st_nx  = S_IDLE;
                    end else begin
                        cnt_nx = cnt + 9'd1;
                    end
                end
                default: begin
                    st_nx  = S_IDLE;
                    cnt_nx = '0;
                end
            endcase
            if (done && tot > NSLOT) begin
                err   = 1'b1;
                ecode = E_OVF;
            end
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= S_IDLE;
            cnt <= '0;
            tot <= '0;
            wr  <= 1'b0;
        end else begin
            st  <= st_nx;
            cnt <= cnt_nx;
            tot <= tot_nx;
            wr  <= wr_nx;
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rec_valid <= 1'b0;
            err_valid <= 1'b0;
            err_code  <= E_NONE;
        end else begin
            rec_valid <= done;
            err_valid <= err;
            err_code  <= err ? ecode : E_NONE;
        end
    end

    a_r12_valid_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |=> !rec_valid);
    a_r12_err_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |=> !err_valid);
    a_r4_no_rec_on_size_err: assert property (@(posedge clk) disable iff (!rst_n)
        (err_valid && err_code == E_SIZE) |-> !rec_valid);
    a_r11_ovf_with_rec: assert property (@(posedge clk) disable iff (!rst_n)
        (err_valid && err_code == E_OVF) |-> rec_valid);
    a_r8_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_SYNC && frame_n && (lad == SYNC_SWAIT || lad == SYNC_LWAIT)) |=> st == S_SYNC);
    a_r9_abort_ends_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_ABORT && cnt == 9'd2) |=> st == S_IDLE);
    a_r11_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_WDATA || st == S_RDATA) |-> cnt < tot);

endmodule

// File: rtl/fwcyc_capture.sv
module fwcyc_capture #(
    parameter int MAX_BYTES = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [3:0]             lad,
    input  logic [8:0]             cnt,
    input  logic                   cap_sel,
    input  logic                   cap_addr,
    input  logic                   cap_size,
    input  logic                   cap_data,
    input  logic                   clr,
    output logic [3:0]             sel,
    output logic [27:0]            addr,
    output logic [3:0]             size,
    output logic [8*MAX_BYTES-1:0] data
);

    localparam int NSLOT = 2 * MAX_BYTES;

    logic [3:0] slot_q [NSLOT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel  <= '0;
            addr <= '0;
            size <= '0;
        end else begin
            if (cap_sel)  sel  <= lad;
            if (cap_addr) addr <= {addr[23:0], lad};
            if (cap_size) size <= lad;
        end
    end

    // Nibble slot j holds byte j/2, low half when j is even.
    for (genvar j = 0; j < NSLOT; j++) begin : g_slot
        localparam logic [8:0] IDX = 9'(j);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[j] <= '0;
            end else if (clr) begin
                slot_q[j] <= '0;
            end else if (cap_data && cnt == IDX) begin
                slot_q[j] <= lad;
            end
        end
        assign data[4*j +: 4] = slot_q[j];
    end

endmodule

// File: rtl/fwcyc_snoop.sv
module fwcyc_snoop
    import fwcyc_pkg::*;
#(
    parameter int MAX_BYTES = 16,
    localparam int DW = 8 * MAX_BYTES,
    localparam int BW = $clog2(MAX_BYTES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lpc_frame_n,
    input  logic [3:0]    lpc_lad,
    output logic          rec_valid,
    output logic          rec_write,
    output logic [3:0]    rec_sel,
    output logic [27:0]   rec_addr,
    output logic [3:0]    rec_size,
    output logic [DW-1:0] rec_data,
    output logic [BW-1:0] rec_bytes,
    output logic          err_valid,
    output logic [1:0]    err_code
);

    localparam logic [7:0] MAXB = 8'(MAX_BYTES);

    logic [8:0] cnt;
    logic       cap_sel, cap_addr, cap_size, cap_data, clr;
    logic [7:0] sz_b;

    fwcyc_ctrl #(.MAX_BYTES(MAX_BYTES)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_n   (lpc_frame_n),
        .lad       (lpc_lad),
        .cnt       (cnt),
        .cap_sel   (cap_sel),
        .cap_addr  (cap_addr),
        .cap_size  (cap_size),
        .cap_data  (cap_data),
        .clr       (clr),
        .wr        (rec_write),
        .rec_valid (rec_valid),
        .err_valid (err_valid),
        .err_code  (err_code)
    );

    fwcyc_capture #(.MAX_BYTES(MAX_BYTES)) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .lad      (lpc_lad),
        .cnt      (cnt),
        .cap_sel  (cap_sel),
        .cap_addr (cap_addr),
        .cap_size (cap_size),
        .cap_data (cap_data),
        .clr      (clr),
        .sel      (rec_sel),
        .addr     (rec_addr),
        .size     (rec_size),
        .data     (rec_data)
    );

    assign sz_b      = size_bytes(rec_size);
    assign rec_bytes = (sz_b > MAXB) ? BW'(MAX_BYTES) : BW'(sz_b);

endmodule

// File: tb/fwcyc_snoop_bench.sv
`timescale 1ns/1ps
module fwcyc_snoop_bench;

    localparam int MAXB = 4;
    localparam int DW   = 8 * MAXB;
    localparam int BW   = $clog2(MAXB + 1);

    typedef struct {
        bit          rec;
        bit          err;
        logic [1:0]  code;
        bit          wr;
        logic [3:0]  sel;
        logic [27:0] addr;
        logic [3:0]  size;
        logic [DW-1:0] data;
        int          bytes;
        string       tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_n = 1'b1;
    logic [3:0]    lad = 4'hF;
    logic          rec_valid, rec_write, err_valid;
    logic [3:0]    rec_sel, rec_size;
    logic [27:0]   rec_addr;
    logic [DW-1:0] rec_data;
    logic [BW-1:0] rec_bytes;
    logic [1:0]    err_code;

    int   n_chk = 0;
    int   n_fail = 0;
    bit   finished = 0;
    exp_t q[$];

    always #4 clk = ~clk;

    fwcyc_snoop #(.MAX_BYTES(MAXB)) u_fwcyc_snoop (
        .clk(clk), .rst_n(rst_n), .lpc_frame_n(frame_n), .lpc_lad(lad),
        .rec_valid(rec_valid), .rec_write(rec_write), .rec_sel(rec_sel),
        .rec_addr(rec_addr), .rec_size(rec_size), .rec_data(rec_data),
        .rec_bytes(rec_bytes), .err_valid(err_valid), .err_code(err_code)
    );

    task automatic nib(input logic f, input logic [3:0] v);
        @(negedge clk);
        frame_n = f;
        lad = v;
    endtask

    task automatic head(input bit wr, input logic [3:0] sel, input logic [27:0] addr);
        nib(1'b0, wr ? 4'hE : 4'hD);
        nib(1'b1, sel);
        for (int i = 0; i < 7; i++) nib(1'b1, addr[27-4*i -: 4]);
    endtask

    function automatic logic [7:0] pat(input logic [7:0] seed, input int k);
        return seed + 8'(k) * 8'h13;
    endfunction

    task automatic run_cycle(input bit wr, input logic [3:0] sel, input logic [27:0] addr,
                             input logic [3:0] sz, input int nb, input logic [7:0] seed,
                             input int waits, input logic [3:0] rdy, input string tag);
        exp_t e;
        logic [7:0] b;
        e.rec = 1; e.wr = wr; e.sel = sel; e.addr = addr; e.size = sz;
        e.err = (nb > MAXB); e.code = (nb > MAXB) ? 2'd3 : 2'd0;
        e.bytes = (nb > MAXB) ? MAXB : nb;
        e.data = '0;
        for (int k = 0; k < nb && k < MAXB; k++) e.data[8*k +: 8] = pat(seed, k);
        e.tag = tag;
        q.push_back(e);
        head(wr, sel, addr);
        nib(1'b1, sz);
        if (wr) begin
            for (int k = 0; k < nb; k++) begin
                b = pat(seed, k);
                nib(1'b1, b[3:0]); nib(1'b1, b[7:4]);
            end
        end
        nib(1'b1, 4'hF); nib(1'b1, 4'hF);
        for (int w = 0; w < waits; w++) nib(1'b1, (w % 2 == 0) ? 4'b0101 : 4'b0110);
        nib(1'b1, rdy);
        if (!wr) begin
            for (int k = 0; k < nb; k++) begin
                b = pat(seed, k);
                nib(1'b1, b[3:0]); nib(1'b1, b[7:4]);
            end
        end
        nib(1'b1, 4'hF); nib(1'b1, 4'hF);
    endtask

    task automatic push_err(input logic [1:0] code, input string tag);
        exp_t e;
        e.rec = 0; e.err = 1; e.code = code; e.wr = 0; e.sel = '0; e.addr = '0;
        e.size = '0; e.data = '0; e.bytes = 0; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // Monitor / scoreboard
    initial begin
        exp_t e;
        bit bad;
        forever begin
            @(posedge clk);
            #2;
            if (rst_n && (rec_valid || err_valid)) begin
                n_chk++;
                if (q.size() == 0) begin
                    n_fail++;
                    $display("FAIL R1 R10 unexpected output: rec=%0b err=%0b code=%0d, expected none",
                             rec_valid, err_valid, err_code);
                end else begin
                    e = q.pop_front();
                    bad = (rec_valid != e.rec) || (err_valid != e.err) ||
                          (e.err && err_code != e.code);
                    if (e.rec)
                        bad = bad || (rec_write != e.wr) || (rec_sel != e.sel) ||
                              (rec_addr != e.addr) || (rec_size != e.size) ||
                              (rec_data != e.data) || (int'(rec_bytes) != e.bytes);
                    if (bad) begin
                        n_fail++;
                        $display("FAIL %s: got rec=%0b err=%0b code=%0d wr=%0b sel=%h addr=%h size=%h data=%h bytes=%0d; expected rec=%0b err=%0b code=%0d wr=%0b sel=%h addr=%h size=%h data=%h bytes=%0d",
                                 e.tag, rec_valid, err_valid, err_code, rec_write, rec_sel, rec_addr,
                                 rec_size, rec_data, rec_bytes, e.rec, e.err, e.code, e.wr, e.sel,
                                 e.addr, e.size, e.data, e.bytes);
                    end
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        n_chk++;
        if (rec_valid !== 1'b0 || err_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R12 reset: rec=%0b err=%0b, expected 0 0", rec_valid, err_valid);
        end
        // R1: a non-firmware start while idle is ignored
        nib(1'b0, 4'h0); nib(1'b1, 4'h3); nib(1'b1, 4'h1); nib(1'b1, 4'hF);

        run_cycle(1, 4'h3, 28'h1234567, 4'b0000, 1, 8'hA5, 2, 4'b0000,
                  "R1 R2 R3 R5 R7 R8 write 1 byte");
        run_cycle(0, 4'hC, 28'hFEDCBA9, 4'b0010, 4, 8'h21, 3, 4'b1001,
                  "R1 R3 R6 R7 R8 read 4 bytes");
        run_cycle(0, 4'h0, 28'h0000001, 4'b0001, 2, 8'h7E, 0, 4'b0000,
                  "R3 R6 R7 read 2 bytes");
        run_cycle(1, 4'h9, 28'h8000000, 4'b0100, 16, 8'h05, 1, 4'b0000,
                  "R3 R5 R11 write 16 bytes overflow");
        run_cycle(0, 4'h5, 28'h0ABCDEF, 4'b0111, 128, 8'hC3, 1, 4'b0000,
                  "R3 R6 R11 read 128 bytes overflow");

        // R4: invalid size code, then stray nibbles must not produce output
        push_err(2'd1, "R4 invalid size");
        head(1, 4'h2, 28'h1111111);
        nib(1'b1, 4'b0011);
        nib(1'b1, 4'h0); nib(1'b1, 4'h0); nib(1'b1, 4'hF);
        run_cycle(1, 4'h4, 28'h2468ACE, 4'b0000, 1, 8'h3C, 0, 4'b0000,
                  "R4 idle after invalid size");

        // R9: abort during SYNC, bus ignored for three clocks
        push_err(2'd2, "R9 abort in sync");
        head(0, 4'h6, 28'h3333333);
        nib(1'b1, 4'b0000); nib(1'b1, 4'hF); nib(1'b1, 4'hF);
        nib(1'b1, 4'b0101);
        nib(1'b0, 4'hF); nib(1'b0, 4'hE); nib(1'b0, 4'hE); nib(1'b0, 4'hE);
        nib(1'b1, 4'hF);
        run_cycle(0, 4'h7, 28'h5555AAA, 4'b0001, 2, 8'h90, 1, 4'b0000,
                  "R9 cycle after abort");

        // R10: restart in the middle of the address
        nib(1'b0, 4'hE); nib(1'b1, 4'h1); nib(1'b1, 4'hA); nib(1'b1, 4'hB); nib(1'b1, 4'hC);
        run_cycle(0, 4'h8, 28'h7654321, 4'b0000, 1, 8'h6D, 0, 4'b0000,
                  "R10 restart mid address");

        // R10: non-firmware start drops a partial cycle silently
        nib(1'b0, 4'hD); nib(1'b1, 4'h2); nib(1'b1, 4'h4); nib(1'b1, 4'h4);
        nib(1'b0, 4'h0); nib(1'b1, 4'h0); nib(1'b1, 4'h0); nib(1'b1, 4'h0);
        nib(1'b1, 4'h0); nib(1'b1, 4'hF); nib(1'b1, 4'hF);
        run_cycle(1, 4'hB, 28'h0F0F0F0, 4'b0010, 4, 8'hE1, 1, 4'b1001,
                  "R10 R12 cycle after dropped one");

        repeat (6) @(negedge clk);
        n_chk++;
        if (q.size() != 0) begin
            n_fail++;
            $display("FAIL R12 missing outputs: %0d pending, expected 0", q.size());
        end
        summary();
    end

endmodule